// File: doc/BRIEF.md
# Instruction-Address Breakpoint Unit

This unit sits beside the decode stage of a small CPU core. It raises a breakpoint interrupt request just before the instruction at a programmed address runs. It has two independent match channels, numbered 0 and 1. Each channel holds a 20-bit instruction start address and an arm bit. A single write port sets both values for one channel at a time.

Each cycle, the decoder presents three things: the start address of the instruction about to execute, a valid strobe, and a one-bit class flag. The class flag is set when the instruction needs a return offset of two bytes. This covers opcodes that are two bytes long, and the short one-byte forms that carry an immediate byte. When an armed channel matches a presented instruction, the unit does three things in the following cycle:

- It pulses a request for one cycle.
- It names the channel that matched, so the two channels vector separately.
- It supplies the value to push onto the stack, which is the matched address plus one or plus two, chosen by the class flag.

No global interrupt mask or priority level gates the request.

Channel 0 wins when both channels match the same instruction. After a channel fires, it will not fire again on the same instruction address until the decoder presents a different address. This stops a handler that returns to the breakpointed instruction from re-entering endlessly.

Top module: `brk_unit`

## Requirements
- R1: After reset, both channels are disarmed with address 0. `irq_req`, `irq_chan` and `irq_ret_pc` are all 0, so presenting address 0 raises no request.
- R2: When `fetch_valid` is 1 and `fetch_pc` equals the address of an armed channel, `irq_req` is 1 in the next cycle, and only for that cycle. In that same cycle `irq_chan` gives the channel number (0 or 1).
- R3: No request is raised when the address differs from every armed address, when the matching channel is disarmed, or when `fetch_valid` is 0.
- R4: With a request, `irq_ret_pc` equals the matched address plus 2 when `fetch_long` was 1, and plus 1 when it was 0. The sum wraps modulo 2^20.
- R5: When both armed channels match the same presentation, only one request is issued, and `irq_chan` is 0.
- R6: After a channel fires, later valid presentations of that same address do not fire that channel again, even across cycles where `fetch_valid` is 0. A valid presentation of a different address re-enables the channel. A channel that lost on priority (R5) can still fire on the next presentation of that address.
- R7: A write with `wr_en`=1 sets the address and arm bit of the channel selected by `wr_ch` (0 or 1), and leaves the other channel unchanged. The write also clears the R6 block of the written channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one channel's settings |
| wr_ch | input | 1 | Channel selected by the write |
| wr_addr | input | 20 | Instruction start address to watch |
| wr_arm | input | 1 | Arm bit: 1 enables the channel |
| fetch_valid | input | 1 | An instruction is about to execute |
| fetch_pc | input | 20 | Start address of that instruction |
| fetch_long | input | 1 | Class flag: 1 selects a return offset of +2, 0 selects +1 |
| irq_req | output | 1 | One-cycle breakpoint request |
| irq_chan | output | 1 | Channel that raised the request |
| irq_ret_pc | output | 20 | Value to push onto the stack |

## Verification
A wrong internal state shows at the ports within one cycle of the next matching presentation:

- A corrupted address register or arm bit shows up as a missing or spurious request.
- A stuck block flag shows up either as a repeat request on the same address or as silence after a different address has been presented.

The directed scenarios therefore revisit addresses and interleave idle cycles, writes and priority collisions. Every check of `irq_req`, `irq_chan` and `irq_ret_pc` is made in the cycle right after the presentation that caused it.

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_ch,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_arm,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          fetch_long,
  output logic          irq_req,
  output logic          irq_chan,
  output logic [AW-1:0] irq_ret_pc
);

  logic [AW-1:0] addr_q [2];
  logic [1:0]    arm_q;
  logic [1:0]    blk_q;
  logic [1:0]    eq;
  logic [1:0]    hit;
  logic [1:0]    fire;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    assign eq[i]  = fetch_valid && (fetch_pc == addr_q[i]);
    assign hit[i] = eq[i] && arm_q[i] && !blk_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
        arm_q[i]  <= 1'b0;
        blk_q[i]  <= 1'b0;
      end else if (wr_en && wr_ch == 1'(i)) begin
        addr_q[i] <= wr_addr;
        arm_q[i]  <= wr_arm;
        blk_q[i]  <= 1'b0;
      end else if (fire[i]) begin
        blk_q[i]  <= 1'b1;
      end else if (fetch_valid && !eq[i]) begin
        blk_q[i]  <= 1'b0;
      end
    end
  end

  assign fire[0] = hit[0];
  assign fire[1] = hit[1] && !hit[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      irq_chan   <= 1'b0;
      irq_ret_pc <= '0;
    end else begin
      irq_req    <= |fire;
      irq_chan   <= fire[1];
      irq_ret_pc <= (|fire) ? fetch_pc + (fetch_long ? AW'(2) : AW'(1)) : '0;
    end
  end

endmodule

module brk_unit_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_pc,
  input logic          fetch_long,
  input logic          irq_req,
  input logic          irq_chan,
  input logic [AW-1:0] irq_ret_pc
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> !irq_req);

  p_from_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(fetch_valid));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !irq_req);

  p_ret_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_ret_pc == $past(fetch_pc) + ($past(fetch_long) ? AW'(2) : AW'(1)));

  p_no_refire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && fetch_valid && !wr_en && fetch_pc == $past(fetch_pc))
      |=> !(irq_req && irq_chan == $past(irq_chan)));

endmodule

bind brk_unit brk_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_brk_unit.sv
module sim_brk_unit;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_ch = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          wr_arm = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          fetch_long = 1'b0;
  logic          irq_req;
  logic          irq_chan;
  logic [AW-1:0] irq_ret_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brk_unit #(.AW(AW)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [AW-1:0] a, input logic arm);
    @(negedge clk);
    fetch_valid = 1'b0;
    wr_en = 1'b1; wr_ch = ch; wr_addr = a; wr_arm = arm;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic show(input logic v, input logic [AW-1:0] pc, input logic lg);
    @(negedge clk);
    fetch_valid = v; fetch_pc = pc; fetch_long = lg;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    show(1'b0, fetch_pc, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 irq_req", irq_req, 0);
    chk("R1 irq_chan", irq_chan, 0);
    chk("R1 irq_ret_pc", irq_ret_pc, 0);
    show(1'b1, 20'h00000, 1'b0);
    chk("R1 disarmed at addr 0", irq_req, 0);
  endtask

  task automatic t_basic();
    wr(1'b0, 20'h01234, 1'b1);
    show(1'b1, 20'h01234, 1'b0);
    chk("R2 req", irq_req, 1);
    chk("R2 chan", irq_chan, 0);
    chk("R4 +1", irq_ret_pc, 20'h01235);
    idle();
    chk("R2 one-cycle pulse", irq_req, 0);
  endtask

  task automatic t_long();
    wr(1'b1, 20'h0ABCD, 1'b1);
    show(1'b1, 20'h0ABCD, 1'b1);
    chk("R2 req ch1", irq_req, 1);
    chk("R2 chan ch1", irq_chan, 1);
    chk("R4 +2", irq_ret_pc, 20'h0ABCF);
    wr(1'b1, 20'hFFFFF, 1'b1);
    show(1'b1, 20'hFFFFF, 1'b1);
    chk("R4 wrap req", irq_req, 1);
    chk("R4 wrap value", irq_ret_pc, 20'h00001);
  endtask

  task automatic t_miss();
    show(1'b1, 20'h01235, 1'b0);
    chk("R3 mismatch", irq_req, 0);
    show(1'b0, 20'h01234, 1'b0);
    chk("R3 invalid strobe", irq_req, 0);
    wr(1'b0, 20'h01234, 1'b0);
    show(1'b1, 20'h01234, 1'b0);
    chk("R3 disarmed", irq_req, 0);
  endtask

  task automatic t_prio();
    wr(1'b0, 20'h00200, 1'b1);
    wr(1'b1, 20'h00200, 1'b1);
    show(1'b1, 20'h00200, 1'b1);
    chk("R5 req", irq_req, 1);
    chk("R5 chan0 wins", irq_chan, 0);
    show(1'b1, 20'h00200, 1'b1);
    chk("R6 loser fires next", irq_req, 1);
    chk("R6 loser chan", irq_chan, 1);
    show(1'b1, 20'h00200, 1'b1);
    chk("R6 both blocked", irq_req, 0);
    show(1'b1, 20'h00300, 1'b0);
    chk("R3 other addr", irq_req, 0);
    show(1'b1, 20'h00200, 1'b0);
    chk("R6 rearmed req", irq_req, 1);
    chk("R6 rearmed chan", irq_chan, 0);
  endtask

  task automatic t_block();
    wr(1'b1, 20'h00000, 1'b0);
    wr(1'b0, 20'h00400, 1'b1);
    show(1'b1, 20'h00400, 1'b0);
    chk("R6 first", irq_req, 1);
    show(1'b1, 20'h00400, 1'b0);
    chk("R6 repeat blocked", irq_req, 0);
    idle();
    show(1'b1, 20'h00400, 1'b0);
    chk("R6 blocked across idle", irq_req, 0);
    wr(1'b1, 20'h00777, 1'b1);
    show(1'b1, 20'h00400, 1'b0);
    chk("R7 other channel write keeps block", irq_req, 0);
    wr(1'b0, 20'h00400, 1'b1);
    show(1'b1, 20'h00400, 1'b0);
    chk("R7 write clears block", irq_req, 1);
    chk("R7 ch0 value", irq_ret_pc, 20'h00401);
    show(1'b1, 20'h00777, 1'b1);
    chk("R7 ch1 written", irq_req, 1);
    chk("R7 ch1 chan", irq_chan, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_long();
    t_miss();
    t_prio();
    t_block();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule